// File: doc/BRIEF.md
# Level-2 Cache Controller Register Stub

This block answers the register accesses that software makes to a level-2 cache controller, but it holds no cache storage at all. It decodes a 4 KB window on a simple 32-bit register bus with separate read and write strobes. It holds the control, auxiliary, latency and address-filter registers, so that driver code can configure the cache and read its settings back. Cache maintenance requests are accepted and always report that they have finished.

The cache-type word is not a plain constant. Each read merges the associativity and way-size bits of the auxiliary register into the stored word, and the merged result is kept. A bit set by one read therefore stays set until reset, even after the auxiliary register is changed. Any access to an offset with no meaning raises a one-cycle error pulse and leaves every register as it was.

Top module: `cache_ctrl_stub`

## Requirements
- R1: Only address bits [11:0] select a register, so every register repeats every 4 KB whatever the upper address bits are.
- R2: A read of offset 0x000 returns 0x410000C8. A write to 0x000 or to 0x004 changes nothing and is flagged as a bad access.
- R3: A read of offset 0x004 returns the stored cache-type word ORed with F<<18 and F<<6, where F is the 5-bit value {aux[19:17], 1'b0, aux[16]}.
- R4: Every read of 0x004 stores its returned value as the new cache-type word, so a bit once set stays set until reset.
- R5: A write to offset 0x100 keeps only data bit 0, and reads of 0x100 return zero in bits [31:1].
- R6: Offsets 0x104 (auxiliary), 0x108 (tag latency), 0x10C (data latency), 0xC00 (filter start) and 0xC04 (filter end) are 32-bit registers that read back exactly what was written.
- R7: Any offset from 0x730 up to and including 0x7FF reads as zero, which means the maintenance operation has finished. Writes there are ignored and never flagged.
- R8: Offsets 0xF40, 0xF60 and 0xF80 read as zero, ignore writes and are never flagged.
- R9: Synchronous active-high reset clears control, both latency registers and both filter registers to zero, loads 0x02020000 into auxiliary control, and loads 0x1C100100 into the cache-type word.
- R10: A read or write of any other offset returns zero, changes no register, and raises `bus_bad` for exactly the one cycle after the access. `bus_bad` is low after every cycle with no access.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe and holds through cycles with no read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 32 | Byte address; only bits [11:0] are decoded |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_bad | output | 1 | One-cycle pulse after an access to an undecoded offset |

## Verification
The hardest case to reach is the sticky cache-type word. Its history only shows when the auxiliary register is changed between reads of 0x004, and a bit that was once merged in must survive both a later clearing write and further reads. The directed phase sets the associativity and way-size bits, reads the word, clears the auxiliary register, and reads again. The random phase then mixes auxiliary writes with cache-type reads, using random upper address bits, so that many merge histories build up against the bench's running model.

// File: rtl/cstub_pkg.sv
package cstub_pkg;

    localparam int DATA_W = 32;
    localparam int OFF_W  = 12;

    typedef enum logic [3:0] {
        RG_IDENT,
        RG_CTYPE,
        RG_CTRL,
        RG_AUX,
        RG_TAGLAT,
        RG_DATLAT,
        RG_FLT_LO,
        RG_FLT_HI,
        RG_MAINT,
        RG_QUIET,
        RG_BAD
    } region_e;

    typedef struct packed {
        logic              ctrl;
        logic [DATA_W-1:0] aux;
        logic [DATA_W-1:0] tag_lat;
        logic [DATA_W-1:0] dat_lat;
        logic [DATA_W-1:0] flt_lo;
        logic [DATA_W-1:0] flt_hi;
        logic [DATA_W-1:0] ctype;
        logic [DATA_W-1:0] rdata;
        logic              bad;
    } stub_state_t;

endpackage

// File: rtl/cstub_decode.sv
module cstub_decode
    import cstub_pkg::*;
#(
    parameter int          QUIET_N   = 3,
    parameter logic [11:0] MAINT_LO  = 12'h730,
    parameter logic [11:0] MAINT_END = 12'h800
) (
    input  logic [OFF_W-1:0] off,
    output region_e          region
);

    localparam logic [11:0] QUIET_BASE = 12'hF40;
    localparam logic [11:0] QUIET_STEP = 12'h020;

    logic [QUIET_N-1:0] quiet_hit;

    genvar gi;
    generate
        for (gi = 0; gi < QUIET_N; gi++) begin : g_quiet
            localparam logic [11:0] QOFF = QUIET_BASE + 12'(gi) * QUIET_STEP;
            assign quiet_hit[gi] = (off == QOFF);
        end
    endgenerate

    always_comb begin
        region = RG_BAD;
        if (off >= MAINT_LO && off < MAINT_END) begin
            region = RG_MAINT;
        end else if (|quiet_hit) begin
            region = RG_QUIET;
        end else begin
            case (off)
                12'h000: region = RG_IDENT;
                12'h004: region = RG_CTYPE;
                12'h100: region = RG_CTRL;
                12'h104: region = RG_AUX;
                12'h108: region = RG_TAGLAT;
                12'h10C: region = RG_DATLAT;
                12'hC00: region = RG_FLT_LO;
                12'hC04: region = RG_FLT_HI;
                default: region = RG_BAD;
            endcase
        end
    end

endmodule

// File: rtl/cstub_ctype.sv
module cstub_ctype
    import cstub_pkg::*;
(
    input  logic [DATA_W-1:0] aux,
    input  logic [DATA_W-1:0] stored,
    output logic [DATA_W-1:0] merged
);

    localparam int FLD_W  = 5;
    localparam int HI_POS = 18;
    localparam int LO_POS = 6;

    logic [FLD_W-1:0] fld;

    always_comb begin
        fld    = {aux[19:17], 1'b0, aux[16]};
        merged = stored
               | (DATA_W'(fld) << HI_POS)
               | (DATA_W'(fld) << LO_POS);
    end

endmodule

// File: rtl/cache_ctrl_stub.sv
module cache_ctrl_stub
    import cstub_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] ID_WORD    = 32'h410000C8,
    parameter logic [31:0] CTYPE_INIT = 32'h1C100100,
    parameter logic [31:0] AUX_INIT   = 32'h02020000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_bad
);

    stub_state_t       st_d, st_q;
    region_e           region;
    logic [OFF_W-1:0]  off;
    logic [DATA_W-1:0] ctype_merged;

    assign off = bus_addr[OFF_W-1:0];

    cstub_decode u_decode (
        .off    (off),
        .region (region)
    );

    cstub_ctype u_ctype (
        .aux    (st_q.aux),
        .stored (st_q.ctype),
        .merged (ctype_merged)
    );

    always_comb begin
        st_d     = st_q;
        st_d.bad = 1'b0;

        if (bus_rd) begin
            st_d.rdata = '0;
            case (region)
                RG_IDENT:  st_d.rdata = ID_WORD;
                RG_CTYPE: begin
                    st_d.rdata = ctype_merged;
                    st_d.ctype = ctype_merged;
                end
                RG_CTRL:   st_d.rdata = {{(DATA_W-1){1'b0}}, st_q.ctrl};
                RG_AUX:    st_d.rdata = st_q.aux;
                RG_TAGLAT: st_d.rdata = st_q.tag_lat;
                RG_DATLAT: st_d.rdata = st_q.dat_lat;
                RG_FLT_LO: st_d.rdata = st_q.flt_lo;
                RG_FLT_HI: st_d.rdata = st_q.flt_hi;
                RG_BAD:    st_d.bad   = 1'b1;
                default:   st_d.rdata = '0;
            endcase
        end

        if (bus_wr) begin
            case (region)
                RG_CTRL:   st_d.ctrl    = bus_wdata[0];
                RG_AUX:    st_d.aux     = bus_wdata;
                RG_TAGLAT: st_d.tag_lat = bus_wdata;
                RG_DATLAT: st_d.dat_lat = bus_wdata;
                RG_FLT_LO: st_d.flt_lo  = bus_wdata;
                RG_FLT_HI: st_d.flt_hi  = bus_wdata;
                RG_IDENT, RG_CTYPE, RG_BAD: st_d.bad = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ctrl    <= 1'b0;
            st_q.aux     <= AUX_INIT;
            st_q.tag_lat <= '0;
            st_q.dat_lat <= '0;
            st_q.flt_lo  <= '0;
            st_q.flt_hi  <= '0;
            st_q.ctype   <= CTYPE_INIT;
            st_q.rdata   <= '0;
            st_q.bad     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign bus_bad   = st_q.bad;

    // Assertions

    assert_ident_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && off == '0) |=> (bus_rdata == ID_WORD));

    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((st_q.ctype & $past(st_q.ctype)) == $past(st_q.ctype)));

    assert_ctrl_bit_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && off == 12'h100) |=> (bus_rdata[31:1] == '0));

    assert_maint_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && off >= 12'h730 && off < 12'h800) |=> !bus_bad);

    assert_maint_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && off >= 12'h730 && off < 12'h800) |=> (bus_rdata == '0));

    assert_bad_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && region == RG_BAD) |=> bus_bad);

    assert_idle_clean_R10: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd || bus_wr) |=> !bus_bad);

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/cache_ctrl_stub_test.sv
module cache_ctrl_stub_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_bad;

    int checks = 0;
    int errors = 0;

    // reference state
    logic        m_ctrl;
    logic [31:0] m_aux, m_tag, m_dat, m_flo, m_fhi, m_ctype, m_rdata;

    always #2.5 clk = ~clk;

    cache_ctrl_stub uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_bad   (bus_bad)
    );

    function automatic logic [31:0] merge_ct(logic [31:0] aux, logic [31:0] ct);
        logic [31:0] f;
        f = {27'd0, aux[19], aux[18], aux[17], 1'b0, aux[16]};
        return ct | (f << 18) | (f << 6);
    endfunction

    // 0 bad, 1 ident, 2 ctype, 3 ctrl, 4..8 rw regs, 9 silent zero
    function automatic int classify(logic [11:0] o);
        if (o >= 12'h730 && o <= 12'h7FF) return 9;
        if (o == 12'hF40 || o == 12'hF60 || o == 12'hF80) return 9;
        case (o)
            12'h000: return 1;
            12'h004: return 2;
            12'h100: return 3;
            12'h104: return 4;
            12'h108: return 5;
            12'h10C: return 6;
            12'hC00: return 7;
            12'hC04: return 8;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ctrl  = 1'b0;
        m_aux   = 32'h02020000;
        m_tag   = '0;
        m_dat   = '0;
        m_flo   = '0;
        m_fhi   = '0;
        m_ctype = 32'h1C100100;
        m_rdata = '0;
    endtask

    task automatic access(logic [31:0] addr, logic wr, logic rd,
                          logic [31:0] wd, string req);
        int          c;
        logic [31:0] er;
        logic        eb;
        c  = classify(addr[11:0]);
        er = '0;
        eb = 1'b0;
        if (rd) begin
            case (c)
                1: er = 32'h410000C8;
                2: begin er = merge_ct(m_aux, m_ctype); m_ctype = er; end
                3: er = {31'd0, m_ctrl};
                4: er = m_aux;
                5: er = m_tag;
                6: er = m_dat;
                7: er = m_flo;
                8: er = m_fhi;
                0: eb = 1'b1;
                default: er = '0;
            endcase
            m_rdata = er;
        end
        if (wr) begin
            case (c)
                3: m_ctrl = wd[0];
                4: m_aux  = wd;
                5: m_tag  = wd;
                6: m_dat  = wd;
                7: m_flo  = wd;
                8: m_fhi  = wd;
                0, 1, 2: eb = 1'b1;
                default: ;
            endcase
        end
        @(negedge clk);
        bus_addr  = addr;
        bus_wr    = wr;
        bus_rd    = rd;
        bus_wdata = wd;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        check(req, bus_rdata, m_rdata);
        check(req, {31'd0, bus_bad}, {31'd0, eb});
    endtask

    task automatic idle_check();
        @(negedge clk);
        check("R10 idle", {31'd0, bus_bad}, 32'd0);
        check("R11 hold", bus_rdata, m_rdata);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [31:0] r;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset values, R2 ident
        check("R9 reset bad", {31'd0, bus_bad}, 32'd0);
        check("R9 reset rdata", bus_rdata, 32'd0);
        access(32'h000, 0, 1, 0, "R2 ident");
        access(32'h100, 0, 1, 0, "R9 ctrl");
        access(32'h104, 0, 1, 0, "R9 aux");
        access(32'h108, 0, 1, 0, "R9 tag");
        access(32'h10C, 0, 1, 0, "R9 data");
        access(32'hC00, 0, 1, 0, "R9 fstart");
        access(32'hC04, 0, 1, 0, "R9 fend");
        access(32'h004, 0, 1, 0, "R9 R3 ctype");

        // R5 control keeps bit 0
        access(32'h100, 1, 0, 32'hFFFF_FFFF, "R5 wr");
        access(32'h100, 0, 1, 0, "R5 rd");
        access(32'h100, 1, 0, 32'hFFFF_FFFE, "R5 wr0");
        access(32'h100, 0, 1, 0, "R5 rd0");

        // R6 full registers
        access(32'h108, 1, 0, 32'hDEAD_BEEF, "R6 tag");
        access(32'h10C, 1, 0, 32'h1234_5678, "R6 data");
        access(32'hC00, 1, 0, 32'hA5A5_0000, "R6 fstart");
        access(32'hC04, 1, 0, 32'hFFFF_F000, "R6 fend");
        access(32'h108, 0, 1, 0, "R6 tag");
        access(32'h10C, 0, 1, 0, "R6 data");
        access(32'hC00, 0, 1, 0, "R6 fstart");
        access(32'hC04, 0, 1, 0, "R6 fend");

        // R3/R4 sticky merge
        access(32'h104, 1, 0, 32'h000F_0000, "R3 aux");
        access(32'h004, 0, 1, 0, "R3 merge");
        access(32'h104, 1, 0, 32'h0000_0000, "R4 aux clr");
        access(32'h004, 0, 1, 0, "R4 sticky");
        access(32'h004, 0, 1, 0, "R4 sticky again");

        // R2 writes to read-only are flagged and change nothing
        access(32'h000, 1, 0, 32'h0, "R2 wr ident");
        access(32'h004, 1, 0, 32'h0, "R2 wr ctype");
        access(32'h000, 0, 1, 0, "R2 ident after");
        access(32'h004, 0, 1, 0, "R2 ctype after");

        // R7 maintenance range and its edges
        access(32'h730, 1, 1, 32'hFFFF_FFFF, "R7 low");
        access(32'h7FC, 1, 1, 32'hFFFF_FFFF, "R7 high");
        access(32'h72C, 1, 0, 32'h1, "R10 below maint");
        access(32'h800, 0, 1, 0, "R10 above maint");

        // R8 quiet offsets
        access(32'hF40, 1, 1, 32'h1, "R8 f40");
        access(32'hF60, 1, 1, 32'h1, "R8 f60");
        access(32'hF80, 1, 1, 32'h1, "R8 f80");

        // R10 undecoded write changes nothing, pulse lasts one cycle
        access(32'h110, 1, 0, 32'hFFFF_FFFF, "R10 wr bad");
        idle_check();
        access(32'h108, 0, 1, 0, "R10 tag unchanged");
        access(32'hC08, 0, 1, 0, "R10 rd bad");
        idle_check();

        // R1 aliasing
        access(32'h1234_5104, 1, 0, 32'h0001_0000, "R1 alias wr");
        access(32'hFFFF_F104, 0, 1, 0, "R1 alias rd");
        access(32'h8000_0000, 0, 1, 0, "R1 alias ident");

        // R11 hold across idle cycles
        access(32'h10C, 0, 1, 0, "R11 read");
        idle_check();
        idle_check();

        // random phase
        r = $urandom(32'h5EED_0042);
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] o;
            logic [31:0] a;
            int          k;
            k = int'($urandom_range(0, 11));
            case (k)
                0: o = 12'h000;
                1, 2: o = 12'h004;
                3: o = 12'h100;
                4, 5: o = 12'h104;
                6: o = 12'h108;
                7: o = 12'hC04;
                8: o = 12'h730 + 12'($urandom_range(0, 51) * 4);
                9: o = 12'hF40 + 12'($urandom_range(0, 2) * 32);
                default: o = 12'($urandom_range(0, 1023) * 4);
            endcase
            a = {$urandom(), o};
            access(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   $urandom(), "R1 R3 R4 R6 R10 random");
            if ($urandom_range(0, 7) == 0) idle_check();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule